// File: doc/BRIEF.md
# Single-Leg PWM Gate Selector

This block produces the upper and lower gate commands for one inverter half-bridge without any dead-time. Its own center-aligned triangular carrier sets the switching period. A mode code chooses how the leg behaves. In the two current-following modes only one switch of the leg is pulsed and the other stays off. Because the two gates never swap within a period, no blanking gap is needed between them. In the two forced modes the leg is held statically at full positive or full negative voltage. This drives the phase current quickly through zero.

A mode selector upstream presents a mode, a duty count and two compensation counts, then pulses a valid strobe to capture them into a shadow set. The shadow set becomes the working set only at the carrier's zero point, so a new setting always governs a whole period. The pulse of the active switch is lengthened by the compensation count for the current sign in use. The lengthened pulse is clamped so that it neither wraps round nor inverts. The gates come from registers.

Top module: `single_leg_gate`

## Requirements
- R1: While reset is asserted, both gate outputs are low and the carrier output is 0.
- R2: The carrier counts 0,1,…,TOP, then TOP-1,…,1,0 and repeats, changing by exactly one each clock; one period is 2·TOP clocks and contains a single 0.
- R3: In mode code 0 (positive current) the lower gate stays low, and the upper gate is high exactly for carrier values below min(duty + compPos, TOP+1).
- R4: In mode code 1 (negative current) the upper gate stays low, and the lower gate is high exactly for carrier values at or above max(duty − compNeg, 0).
- R5: The compensated thresholds saturate. If duty + compPos exceeds TOP, the upper gate is high for the whole period in mode 0. If compNeg is at least duty, the lower gate is high for the whole period in mode 1.
- R6: In mode code 2 (forced fall through zero) the upper gate is low and the lower gate is high for the entire period, with no toggling.
- R7: In mode code 3 (forced rise through zero) the upper gate is high and the lower gate is low for the entire period, with no toggling.
- R8: The two gate outputs are never high in the same cycle, in any mode or at any mode change.
- R9: Mode, duty and compensation inputs are captured only on a clock where cfgValid is high; input changes without cfgValid have no effect. A captured setting takes effect from the next clock on which the carrier is 0, and not before.
- R10: Each gate output is registered: its value in a cycle reflects the carrier value and working setting of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Strobe capturing the setting inputs into the shadow set |
| modeIn | input | 2 | Leg mode code (0 positive, 1 negative, 2 forced low, 3 forced high) |
| dutyIn | input | CNT_W | Uncompensated on-count threshold |
| compPosIn | input | CNT_W | Extension count used in mode 0 |
| compNegIn | input | CNT_W | Extension count used in mode 1 |
| carrierOut | output | CNT_W | Current carrier value |
| gateHi | output | 1 | Upper switch command |
| gateLo | output | 1 | Lower switch command |

## Verification
A wrong working setting shows at the gates within one clock of the carrier's zero point. It shows as a wrong forced level, as the idle switch pulsing, or as an edge at the wrong carrier value. The bench therefore compares every gate sample on every cycle against its model. A setting loaded early shows up as an edge in the tail of the old period, and it is caught in that same cycle. A counter that misses a turn point shows at carrierOut on the very next clock. Both gates being high at once is checked on every cycle.

// File: rtl/sleg_pkg.sv
package sleg_pkg;

  typedef enum logic [1:0] {
    LEG_POS   = 2'd0,
    LEG_NEG   = 2'd1,
    LEG_PULLD = 2'd2,
    LEG_PUSHU = 2'd3
  } legMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadActive;  // next carrier value is the zero point
    logic rising;      // carrier is on its up slope
  } legStrobe_t;

endpackage

// File: rtl/sleg_ctrl.sv
module sleg_ctrl
  import sleg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOP   = 2500
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [CNT_W-1:0] carrier,
  output legStrobe_t       strb
);
  localparam logic [CNT_W-1:0] TOP_C = CNT_W'(TOP);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic             upQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      upQ  <= 1'b1;
    end else if (upQ) begin
      if (cntQ == TOP_C) begin
        cntQ <= TOP_C - ONE_C;
        upQ  <= 1'b0;
      end else begin
        cntQ <= cntQ + ONE_C;
      end
    end else begin
      if (cntQ == '0) begin
        cntQ <= ONE_C;
        upQ  <= 1'b1;
      end else begin
        cntQ <= cntQ - ONE_C;
      end
    end
  end

  always_comb begin
    strb.loadActive = !upQ && (cntQ == ONE_C);
    strb.rising     = upQ;
  end

  assign carrier = cntQ;

endmodule

// File: rtl/sleg_datapath.sv
module sleg_datapath
  import sleg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOP   = 2500
) (
  input  logic             clk,
  input  logic             rstN,
  input  legStrobe_t       strb,
  input  logic [CNT_W-1:0] carrier,
  input  logic             cfgValid,
  input  logic [1:0]       modeIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [CNT_W-1:0] compPosIn,
  input  logic [CNT_W-1:0] compNegIn,
  output logic             gateHi,
  output logic             gateLo
);
  localparam int THR_W = CNT_W + 1;
  localparam logic [THR_W-1:0] FULL_ON = THR_W'(TOP + 1);

  typedef struct packed {
    legMode_t         mode;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] compPos;
    logic [CNT_W-1:0] compNeg;
  } legCfg_t;

  legCfg_t shadowQ, activeQ;
  logic [THR_W-1:0] hiSum, hiThr, loThr, cntExt;
  logic             hiPulse, loPulse, hiNext, loNext;
  logic             hiQ, loQ;

  // shadow capture and period-boundary transfer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '{mode: LEG_POS, duty: '0, compPos: '0, compNeg: '0};
      activeQ <= '{mode: LEG_POS, duty: '0, compPos: '0, compNeg: '0};
    end else begin
      if (strb.loadActive) activeQ <= shadowQ;
      if (cfgValid) begin
        shadowQ.mode    <= legMode_t'(modeIn);
        shadowQ.duty    <= dutyIn;
        shadowQ.compPos <= compPosIn;
        shadowQ.compNeg <= compNegIn;
      end
    end
  end

  // compensated thresholds, clamped to the period
  always_comb begin
    cntExt = {1'b0, carrier};
    hiSum  = {1'b0, activeQ.duty} + {1'b0, activeQ.compPos};
    hiThr  = (hiSum > FULL_ON) ? FULL_ON : hiSum;
    loThr  = (activeQ.compNeg >= activeQ.duty) ? '0
           : {1'b0, activeQ.duty - activeQ.compNeg};
    hiPulse = cntExt < hiThr;
    loPulse = cntExt >= loThr;
  end

  // mode gating: at most one switch ever commanded on
  always_comb begin
    unique case (activeQ.mode)
      LEG_POS:   begin hiNext = hiPulse; loNext = 1'b0;    end
      LEG_NEG:   begin hiNext = 1'b0;    loNext = loPulse; end
      LEG_PULLD: begin hiNext = 1'b0;    loNext = 1'b1;    end
      LEG_PUSHU: begin hiNext = 1'b1;    loNext = 1'b0;    end
      default:   begin hiNext = 1'b0;    loNext = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ <= 1'b0;
      loQ <= 1'b0;
    end else begin
      hiQ <= hiNext;
      loQ <= loNext;
    end
  end

  assign gateHi = hiQ;
  assign gateLo = loQ;

endmodule

// File: rtl/single_leg_gate.sv
module single_leg_gate
  import sleg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOP   = 2500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgValid,
  input  logic [1:0]       modeIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [CNT_W-1:0] compPosIn,
  input  logic [CNT_W-1:0] compNegIn,
  output logic [CNT_W-1:0] carrierOut,
  output logic             gateHi,
  output logic             gateLo
);
  legStrobe_t       strb;
  logic [CNT_W-1:0] carrier;

  sleg_ctrl #(.CNT_W(CNT_W), .TOP(TOP)) u_ctrl (
    .clk(clk), .rstN(rstN), .carrier(carrier), .strb(strb)
  );

  sleg_datapath #(.CNT_W(CNT_W), .TOP(TOP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .carrier(carrier),
    .cfgValid(cfgValid), .modeIn(modeIn), .dutyIn(dutyIn),
    .compPosIn(compPosIn), .compNegIn(compNegIn),
    .gateHi(gateHi), .gateLo(gateLo)
  );

  assign carrierOut = carrier;

endmodule

// File: rtl/sleg_checker.sv
module sleg_checker #(
  parameter int CNT_W = 12,
  parameter int TOP   = 2500
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] carrier,
  input logic             gateHi,
  input logic             gateLo
);
  localparam logic [CNT_W-1:0] TOP_C = CNT_W'(TOP);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R8: never both switches on
  p_no_shoot_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHi && gateLo));

  // R2: carrier stays inside its range
  p_carrier_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    carrier <= TOP_C);

  // R2: unit steps only
  p_carrier_step_r2: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (carrier == $past(carrier) + 1'b1) || (carrier == $past(carrier) - 1'b1));

  // R2: valley turns upward
  p_carrier_valley_r2: assert property (@(posedge clk) disable iff (!rstN)
    (carrier == '0) |=> (carrier == CNT_W'(1)));

  // R2: peak turns downward
  p_carrier_peak_r2: assert property (@(posedge clk) disable iff (!rstN)
    (carrier == TOP_C) |=> (carrier == TOP_C - 1'b1));

endmodule

bind single_leg_gate sleg_checker #(.CNT_W(CNT_W), .TOP(TOP)) u_chk (
  .clk(clk), .rstN(rstN), .carrier(carrierOut), .gateHi(gateHi), .gateLo(gateLo)
);

// File: tb/single_leg_gate_test.sv
module single_leg_gate_test;
  localparam int CW  = 8;
  localparam int TOP = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgValid = 1'b0;
  logic [1:0]    modeIn = 2'd0;
  logic [CW-1:0] dutyIn = '0, compPosIn = '0, compNegIn = '0;
  logic [CW-1:0] carrierOut;
  logic          gateHi, gateLo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // bench model state
  int cntM = 0, upM = 1;
  int aMode = 0, aDuty = 0, aCp = 0, aCn = 0;
  int sMode = 0, sDuty = 0, sCp = 0, sCn = 0;
  bit eHi = 0, eLo = 0;
  string eTag = "R1";
  string phase = "";

  single_leg_gate #(.CNT_W(CW), .TOP(TOP)) uut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .modeIn(modeIn),
    .dutyIn(dutyIn), .compPosIn(compPosIn), .compNegIn(compNegIn),
    .carrierOut(carrierOut), .gateHi(gateHi), .gateLo(gateLo)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic bit hiExp(int m, int d, int cp, int c);
    int thr;
    thr = (d + cp > TOP + 1) ? TOP + 1 : d + cp;     // R3, R5
    if (m == 3) return 1'b1;                          // R7
    if (m == 0) return c < thr;
    return 1'b0;
  endfunction

  function automatic bit loExp(int m, int d, int cn, int c);
    int thr;
    thr = (cn >= d) ? 0 : d - cn;                     // R4, R5
    if (m == 2) return 1'b1;                          // R6
    if (m == 1) return c >= thr;
    return 1'b0;
  endfunction

  function automatic string tagOf(int m, int d, int cp, int cn);
    case (m)
      0: return (d + cp > TOP) ? "R3 R5" : "R3";
      1: return (cn >= d) ? "R4 R5" : "R4";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at next negedge
  task automatic step(bit v, int m, int d, int cp, int cn);
    cfgValid  = v;
    modeIn    = 2'(m);
    dutyIn    = CW'(d);
    compPosIn = CW'(cp);
    compNegIn = CW'(cn);
    @(posedge clk);
    eHi  = hiExp(aMode, aDuty, aCp, cntM);
    eLo  = loExp(aMode, aDuty, aCn, cntM);
    eTag = tagOf(aMode, aDuty, aCp, aCn);
    if (upM == 0 && cntM == 1) begin   // R9 boundary transfer
      aMode = sMode; aDuty = sDuty; aCp = sCp; aCn = sCn;
    end
    if (v) begin
      sMode = m; sDuty = d; sCp = cp; sCn = cn;
    end
    if (upM == 1) begin
      if (cntM == TOP) begin cntM = TOP - 1; upM = 0; end
      else cntM++;
    end else begin
      if (cntM == 0) begin cntM = 1; upM = 1; end
      else cntM--;
    end
    @(negedge clk);
    check(int'(carrierOut) == cntM, "R2 carrier", int'(carrierOut), cntM);
    check(gateHi == eHi, {eTag, " R10 upper", phase}, int'(gateHi), int'(eHi));
    check(gateLo == eLo, {eTag, " R10 lower", phase}, int'(gateLo), int'(eLo));
    check(!(gateHi && gateLo), "R8 both high", int'({gateHi, gateLo}), 0);
  endtask

  // hold a setting for n clocks with noise on the inputs but no strobe
  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      step(1'b0, int'($urandom_range(3)), int'($urandom_range(40)),
           int'($urandom_range(10)), int'($urandom_range(10)));
  endtask

  initial begin
    void'($urandom(32'h5EED_1E6));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(gateHi == 1'b0 && gateLo == 1'b0, "R1 gates in reset",
          int'({gateHi, gateLo}), 0);
    check(carrierOut == '0, "R1 carrier in reset", int'(carrierOut), 0);
    rstN = 1'b1;

    // R3: positive mode, mid duty
    step(1'b1, 0, 10, 2, 0); idle(2 * TOP * 2);
    // R4: negative mode
    step(1'b1, 1, 14, 0, 3); idle(2 * TOP * 2);
    // R5: saturation in both current modes
    step(1'b1, 0, TOP - 2, 9, 0); idle(2 * TOP * 2);
    step(1'b1, 1, 4, 0, 7); idle(2 * TOP * 2);
    // R6 and R7: forced modes, back to back (no gap between gates)
    step(1'b1, 2, 0, 0, 0); idle(2 * TOP * 2);
    step(1'b1, 3, 0, 0, 0); idle(2 * TOP * 2);
    step(1'b1, 2, 0, 0, 0); idle(2 * TOP * 2);
    // R9: strobe mid-period, effect waits for the zero point
    phase = " R9";
    idle(TOP / 2);
    step(1'b1, 1, 0, 0, 0); idle(2 * TOP * 2);
    step(1'b1, 0, 0, 0, 0); idle(2 * TOP * 2);  // upper never on
    phase = "";
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom_range(15) == 0);
      step(v, int'($urandom_range(3)), int'($urandom_range(TOP + 4)),
           int'($urandom_range(12)), int'($urandom_range(12)));
    end
    done = 1;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 100000) begin
      if (!done) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule